// File: doc/BRIEF.md
# Maskable Power Event Latch with Acknowledge Readout

This block gathers power-management events into an 8-bit pending register and raises an active-low interrupt line whenever a pending bit is also enabled in an 8-bit mask. Two sources feed it. The first is a one-second tick made from the input clock. The second is a peripheral-bus autopoll, which runs every 30 ms while software has enabled it. Each poll asks an external bus agent for data. When the agent answers with a nonzero byte count, that count and the bytes are held in the block until software fetches them.

Software works the block through a command strobe that carries an opcode, an argument count and up to two argument bytes. There are three commands: load the interrupt mask, set the autopoll device mask, and acknowledge. An acknowledge streams its answer out of a reply-byte port, one byte per clock. If poll data is waiting, the acknowledge reports only the two poll-related bits followed by the stored bytes, and clears only those bits. If no poll data is waiting, it reports every pending bit in a single byte and clears them all. The bus transaction itself and the host command transport lie outside the block.

Top module: `pwr_evt_latch`

## Requirements
- R1: `irq_n` is low exactly when (pending AND mask) is nonzero. It reflects each change of pending bits or mask on the first clock edge that makes the change.
- R2: After reset, nothing is pending, the mask is 8'h30 (tick bit 5 and reply bit 4 enabled), autopoll is off, `irq_n` is high, `rsp_valid` is low and `poll_req` is low.
- R3: Every CLK_HZ clock cycles (one second) the tick sets pending bit 5.
- R4: A poll answer with a nonzero length, arriving while bit 4 is clear, sets bit 4 (reply) and bit 0 (autopoll) and stores the length and bytes. A zero-length answer is ignored. While bit 4 is pending, no `poll_req` is raised, any answer is ignored, and the stored data are kept.
- R5: Acknowledge is opcode 1 with zero arguments; with any other argument count it does nothing. With bit 4 pending, the reply is a header byte (pending AND 8'h11) followed by the stored bytes, `poll_rsp_data[7:0]` first. Only bits 4 and 0 are cleared, and the stored length becomes zero.
- R6: An acknowledge with bit 4 clear returns one byte holding all pending bits and clears every pending bit.
- R7: Set-mask is opcode 2 with exactly one argument. It loads `cmd_arg[7:0]` into the mask. With any other argument count it is ignored.
- R8: Set-autopoll is opcode 3 with exactly two arguments. A value different from the current one is stored on `poll_mask` and restarts the 30 ms period. A nonzero value makes `poll_req` pulse once per period; zero stops polling. Writing the value already held leaves the period phase untouched.
- R9: Reply bytes appear on consecutive cycles, starting the cycle after the acknowledge is sampled, with `rsp_last` on the final byte. An acknowledge sampled while a reply is streaming is ignored.
- R10: An event that arrives in the same cycle as an acknowledge clears the pending bits remains pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Opcode: 1 acknowledge, 2 set mask, 3 set autopoll |
| cmd_nargs | input | 3 | Number of argument bytes carried |
| cmd_arg | input | 16 | Argument bytes; the mask uses [7:0] |
| poll_req | output | 1 | One-cycle request to run a bus poll |
| poll_mask | output | 16 | Current autopoll device mask |
| poll_rsp_valid | input | 1 | Poll answer strobe |
| poll_rsp_len | input | LENW | Number of answer bytes; 0 means no data |
| poll_rsp_data | input | 8*NBYTES | Answer bytes, first byte in [7:0] |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_data | output | 8 | Reply byte |
| rsp_last | output | 1 | Final byte of the reply |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench runs the design at a 2 kHz nominal clock, so that one second and 30 ms become short, countable windows. It goes after the priority split in the acknowledge. A design that cleared every bit on a reply acknowledge would lose a pending tick, so the bench acknowledges with both present and then looks for the tick in the next reply. It lines up an acknowledge exactly with a poll answer; a design in which clear beats set would drop that event. It also checks that polls stop while reply data wait, that argument counts outside the rule leave the mask and pending bits alone, that a second acknowledge in the middle of a stream does not cut it short, and that rewriting the same autopoll mask does not reset the 30 ms phase.

// File: rtl/evl_pkg.sv
package evl_pkg;
  // Pending-bit positions; software decodes the acknowledge header by these.
  localparam int B_AUTO = 0;
  localparam int B_RPLY = 4;
  localparam int B_TICK = 5;

  localparam logic [7:0] RPLY_BITS = (8'h01 << B_RPLY) | (8'h01 << B_AUTO);
  localparam logic [7:0] MASK_RST  = (8'h01 << B_RPLY) | (8'h01 << B_TICK);

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ACK  = 2'd1,
    OP_MASK = 2'd2,
    OP_POLL = 2'd3
  } evl_op_e;
endpackage

// File: rtl/evl_timebase.sv
// Millisecond clock enable derived from the input clock.
module evl_timebase #(
  parameter int CYC_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ms_en
);
  generate
    if (CYC_PER_MS <= 1) begin : g_direct
      assign ms_en = 1'b1;
    end else begin : g_count
      localparam int TW = $clog2(CYC_PER_MS);
      logic [TW-1:0] cnt_q, cnt_d;
      logic          wrap;

      always_comb begin
        wrap  = (cnt_q == TW'(CYC_PER_MS - 1));
        cnt_d = wrap ? '0 : cnt_q + TW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign ms_en = wrap;
    end
  endgenerate
endmodule

// File: rtl/evl_period.sv
// Counts millisecond enables and fires once every PERIOD_MS of them.
module evl_period #(
  parameter int PERIOD_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_en,
  input  logic run,
  input  logic restart,
  output logic fire
);
  localparam int PW = (PERIOD_MS > 1) ? $clog2(PERIOD_MS) : 1;

  logic [PW-1:0] cnt_q, cnt_d;
  logic          at_end;

  always_comb begin
    at_end = (cnt_q == PW'(PERIOD_MS - 1));
    if (restart || !run)  cnt_d = '0;
    else if (ms_en)       cnt_d = at_end ? '0 : cnt_q + PW'(1);
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire = run && !restart && ms_en && at_end;
endmodule

// File: rtl/evl_core.sv
// Pending bits, mask, stored poll data and the registered interrupt.
module evl_core
  import evl_pkg::*;
#(
  parameter int NBYTES = 8,
  localparam int LENW = $clog2(NBYTES + 1),
  localparam int CNTW = $clog2(NBYTES + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  poll_valid,
  input  logic [LENW-1:0]       poll_len,
  input  logic [8*NBYTES-1:0]   poll_data,
  input  logic                  mask_we,
  input  logic [7:0]            mask_wd,
  input  logic                  ack,
  output logic [7:0]            pend,
  output logic [7:0]            mask,
  output logic [LENW-1:0]       rply_len,
  output logic                  rply_pend,
  output logic                  irq_n,
  output logic [7:0]            hdr,
  output logic [CNTW-1:0]       total,
  output logic [8*NBYTES-1:0]   store
);
  logic [7:0]          pend_q, pend_d, mask_q, mask_d, set_b, clr_b;
  logic [LENW-1:0]     len_q, len_d, len_clip;
  logic [8*NBYTES-1:0] data_q, data_d;
  logic                irq_q, irq_d, rply, hit;

  always_comb begin
    rply     = pend_q[B_RPLY];
    len_clip = (poll_len > LENW'(NBYTES)) ? LENW'(NBYTES) : poll_len;
    hit      = poll_valid && !rply && (poll_len != '0);

    set_b = '0;
    if (tick) set_b[B_TICK] = 1'b1;
    if (hit)  set_b = set_b | RPLY_BITS;

    clr_b = '0;
    if (ack) clr_b = rply ? RPLY_BITS : 8'hFF;

    // Events win over a same-cycle clear.
    pend_d = (pend_q & ~clr_b) | set_b;
    mask_d = mask_we ? mask_wd : mask_q;

    if (hit)              len_d = len_clip;
    else if (ack && rply) len_d = '0;
    else                  len_d = len_q;
    data_d = hit ? poll_data : data_q;

    irq_d = ~|(pend_d & mask_d);

    hdr   = rply ? (pend_q & RPLY_BITS) : pend_q;
    total = rply ? (CNTW'(len_q) + CNTW'(1)) : CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
      len_q  <= '0;
      data_q <= '0;
      irq_q  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      len_q  <= len_d;
      data_q <= data_d;
      irq_q  <= irq_d;
    end
  end

  assign pend      = pend_q;
  assign mask      = mask_q;
  assign rply_len  = len_q;
  assign rply_pend = rply;
  assign irq_n     = irq_q;
  assign store     = data_q;
endmodule

// File: rtl/evl_serial.sv
// Snapshots a reply and shifts it out one byte per cycle.
module evl_serial #(
  parameter int NBYTES = 8,
  localparam int CNTW = $clog2(NBYTES + 2),
  localparam int SHW  = 8 * (NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [7:0]          hdr,
  input  logic [CNTW-1:0]     total,
  input  logic [8*NBYTES-1:0] body,
  output logic                busy,
  output logic                out_valid,
  output logic [7:0]          out_data,
  output logic                out_last
);
  logic [SHW-1:0]  sh_q, sh_d;
  logic [CNTW-1:0] left_q, left_d;
  logic            live;

  always_comb begin
    live = (left_q != '0);
    if (load) begin
      sh_d   = {body, hdr};
      left_d = total;
    end else if (live) begin
      sh_d   = sh_q >> 8;
      left_d = left_q - CNTW'(1);
    end else begin
      sh_d   = sh_q;
      left_d = left_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign busy      = live;
  assign out_valid = live;
  assign out_data  = sh_q[7:0];
  assign out_last  = (left_q == CNTW'(1));
endmodule

// File: rtl/pwr_evt_latch.sv
module pwr_evt_latch
  import evl_pkg::*;
#(
  parameter int CLK_HZ   = 100000000,
  parameter int NBYTES   = 8,
  parameter int TICK_MS  = 1000,
  parameter int POLL_MS  = 30,
  localparam int LENW = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [2:0]          cmd_nargs,
  input  logic [15:0]         cmd_arg,
  output logic                poll_req,
  output logic [15:0]         poll_mask,
  input  logic                poll_rsp_valid,
  input  logic [LENW-1:0]     poll_rsp_len,
  input  logic [8*NBYTES-1:0] poll_rsp_data,
  output logic                rsp_valid,
  output logic [7:0]          rsp_data,
  output logic                rsp_last,
  output logic                irq_n
);
  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int CNTW = $clog2(NBYTES + 2);

  logic                ms_en, tick, poll_fire, busy;
  logic                ack_ok, mask_ok, ap_ok, ap_chg;
  logic [15:0]         ap_q, ap_d;
  logic [7:0]          pend, mask, hdr;
  logic [LENW-1:0]     rply_len;
  logic                rply_pend;
  logic [CNTW-1:0]     total;
  logic [8*NBYTES-1:0] store;

  // Command decode
  always_comb begin
    ack_ok  = cmd_valid && (cmd_op == OP_ACK)  && (cmd_nargs == 3'd0) && !busy;
    mask_ok = cmd_valid && (cmd_op == OP_MASK) && (cmd_nargs == 3'd1);
    ap_ok   = cmd_valid && (cmd_op == OP_POLL) && (cmd_nargs == 3'd2);
    ap_chg  = ap_ok && (cmd_arg != ap_q);
    ap_d    = ap_chg ? cmd_arg : ap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ap_q <= '0;
    else        ap_q <= ap_d;
  end

  evl_timebase #(.CYC_PER_MS(CYC_PER_MS)) i_tb (
    .clk(clk), .rst_n(rst_n), .ms_en(ms_en)
  );

  evl_period #(.PERIOD_MS(TICK_MS)) i_sec (
    .clk(clk), .rst_n(rst_n), .ms_en(ms_en),
    .run(1'b1), .restart(1'b0), .fire(tick)
  );

  evl_period #(.PERIOD_MS(POLL_MS)) i_poll (
    .clk(clk), .rst_n(rst_n), .ms_en(ms_en),
    .run(ap_q != '0), .restart(ap_chg), .fire(poll_fire)
  );

  evl_core #(.NBYTES(NBYTES)) i_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .poll_valid(poll_rsp_valid), .poll_len(poll_rsp_len), .poll_data(poll_rsp_data),
    .mask_we(mask_ok), .mask_wd(cmd_arg[7:0]), .ack(ack_ok),
    .pend(pend), .mask(mask), .rply_len(rply_len), .rply_pend(rply_pend),
    .irq_n(irq_n), .hdr(hdr), .total(total), .store(store)
  );

  evl_serial #(.NBYTES(NBYTES)) i_ser (
    .clk(clk), .rst_n(rst_n), .load(ack_ok), .hdr(hdr), .total(total),
    .body(store), .busy(busy), .out_valid(rsp_valid), .out_data(rsp_data),
    .out_last(rsp_last)
  );

  assign poll_req  = poll_fire && !rply_pend;
  assign poll_mask = ap_q;
endmodule

// File: rtl/evl_checker.sv
module evl_checker
  import evl_pkg::*;
#(
  parameter int LENW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack_ok,
  input logic            mask_ok,
  input logic [15:0]     cmd_arg,
  input logic [7:0]      pend,
  input logic [7:0]      mask,
  input logic [LENW-1:0] rply_len,
  input logic            irq_n,
  input logic            rsp_valid,
  input logic            rsp_last
);
  // R1
  p_irq_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ~|(pend & mask));

  // R7
  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ok |=> mask == $past(cmd_arg[7:0]));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_ok |=> $stable(mask));

  // R4
  p_reply_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[B_RPLY] && !ack_ok) |=> (pend[B_RPLY] && $stable(rply_len)));

  // R5
  p_ack_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && pend[B_RPLY]) |=>
      (!pend[B_RPLY] && !pend[B_AUTO] && rply_len == '0 &&
       (pend[B_TICK] || !$past(pend[B_TICK]))));

  // R9
  p_rsp_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> !rsp_valid);

  p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);
endmodule

bind pwr_evt_latch evl_checker #(.LENW(LENW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ack_ok(ack_ok), .mask_ok(mask_ok),
  .cmd_arg(cmd_arg), .pend(pend), .mask(mask), .rply_len(rply_len),
  .irq_n(irq_n), .rsp_valid(rsp_valid), .rsp_last(rsp_last)
);

// File: tb/test_pwr_evt_latch.sv
`timescale 1ns/1ps
module test_pwr_evt_latch;
  localparam int NB   = 8;
  localparam int LENW = $clog2(NB + 1);

  logic            clk, rst_n;
  logic            cmd_valid;
  logic [1:0]      cmd_op;
  logic [2:0]      cmd_nargs;
  logic [15:0]     cmd_arg;
  logic            poll_req;
  logic [15:0]     poll_mask;
  logic            poll_rsp_valid;
  logic [LENW-1:0] poll_rsp_len;
  logic [8*NB-1:0] poll_rsp_data;
  logic            rsp_valid, rsp_last, irq_n;
  logic [7:0]      rsp_data;

  pwr_evt_latch #(.CLK_HZ(2000), .NBYTES(NB)) i_pwr_evt_latch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_nargs(cmd_nargs), .cmd_arg(cmd_arg), .poll_req(poll_req),
    .poll_mask(poll_mask), .poll_rsp_valid(poll_rsp_valid),
    .poll_rsp_len(poll_rsp_len), .poll_rsp_data(poll_rsp_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Bus agent: answers every poll request one cycle later.
  logic [LENW-1:0] arm_len;
  logic [8*NB-1:0] arm_data;
  int npoll = 0;
  int nhit = 0;
  always @(negedge clk) begin
    poll_rsp_valid <= 1'b0;
    if (rst_n && poll_req) begin
      poll_rsp_valid <= 1'b1;
      poll_rsp_len   <= arm_len;
      poll_rsp_data  <= arm_data;
      npoll = npoll + 1;
      if (arm_len != '0) begin
        nhit = nhit + 1;
        arm_len = '0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [2:0] na, input logic [15:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_nargs = na; cmd_arg = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  logic [7:0] rb [10];
  int rn, rlast;

  // Reads the reply now on the port; optionally issues another ack at byte inj.
  task automatic get_reply(input int inj);
    rn = 0; rlast = -1;
    while (rsp_valid && rn < 10) begin
      rb[rn] = rsp_data;
      if (rsp_last) rlast = rn;
      if (rn == inj) begin
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_nargs = 3'd0; cmd_arg = '0;
      end
      rn++;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  task automatic check_reply(input string req, input int n, input logic [31:0] e);
    chk({req, " reply length"}, rn, n);
    chk({req, " last marker"}, rlast, n - 1);
    for (int k = 0; k < n && k < 4; k++)
      chk({req, " reply byte"}, rb[k], e[8*k +: 8]);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic time_poll(output int n);
    n = 0;
    while (!poll_req && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int n, p0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_nargs = '0; cmd_arg = '0;
    arm_len = '0; arm_data = '0;
    poll_rsp_len = '0; poll_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 reset state
    chk("R2 irq_n", irq_n, 1);
    chk("R2 rsp_valid", rsp_valid, 0);
    chk("R2 poll_req", poll_req, 0);
    chk("R2 poll_mask", poll_mask, 0);

    // R5 ack with an argument is ignored
    do_cmd(2'd1, 3'd1, 16'h0);
    chk("R5 ack nargs=1 ignored", rsp_valid, 0);
    // R6 ack with nothing pending
    do_cmd(2'd1, 3'd0, 16'h0);
    get_reply(-1);
    check_reply("R6 empty", 1, 32'h00);

    // R3 tick after one second, R2 tick enabled by default mask
    wait_cyc(1990);
    chk("R3 no tick before 1 s", irq_n, 1);
    wait_cyc(2010);
    chk("R3 R2 tick raises irq", irq_n, 0);

    do_cmd(2'd2, 3'd1, 16'h0000);
    chk("R7 R1 mask 0 releases irq", irq_n, 1);
    do_cmd(2'd2, 3'd2, 16'h00FF);
    chk("R7 mask nargs=2 ignored", irq_n, 1);
    do_cmd(2'd2, 3'd1, 16'h0020);
    chk("R7 R1 mask 0x20 asserts irq", irq_n, 0);
    do_cmd(2'd1, 3'd0, 16'h0);
    get_reply(-1);
    check_reply("R6 tick", 1, 32'h20);
    chk("R6 R1 irq after clear", irq_n, 1);

    // R8 autopoll start, R4 reply capture
    arm_len = LENW'(3); arm_data = 64'h0000_0000_00C3_B2A1;
    do_cmd(2'd3, 3'd2, 16'h0005);
    chk("R8 poll_mask", poll_mask, 16'h0005);
    time_poll(n);
    chk("R8 first poll near 60 cycles", (n >= 55 && n <= 63), 1);
    repeat (3) @(negedge clk);
    chk("R1 reply masked off", irq_n, 1);
    do_cmd(2'd2, 3'd1, 16'h0010);
    chk("R4 R1 reply bit pending", irq_n, 0);
    p0 = npoll;
    repeat (150) @(negedge clk);
    chk("R4 polls suppressed", npoll - p0, 0);
    do_cmd(2'd1, 3'd2, 16'h0);
    chk("R5 ack nargs=2 ignored", rsp_valid, 0);
    chk("R5 pending kept", irq_n, 0);
    do_cmd(2'd1, 3'd0, 16'h0);
    get_reply(-1);
    check_reply("R5 R9 reply", 4, 32'hC3B2A111);
    chk("R5 R1 irq after reply ack", irq_n, 1);

    // R5 tick kept across reply ack, R9 ack during stream ignored
    wait_cyc(4030);
    chk("R1 tick masked", irq_n, 1);
    p0 = nhit;
    arm_data = 64'h0000_0000_0000_6B5A;
    arm_len = LENW'(2);
    while (nhit == p0) @(negedge clk);
    repeat (2) @(negedge clk);
    do_cmd(2'd1, 3'd0, 16'h0);
    get_reply(1);
    check_reply("R5 R9 reply with tick", 3, 32'h006B5A11);
    repeat (3) @(negedge clk);
    chk("R9 mid-stream ack ignored", rsp_valid, 0);
    do_cmd(2'd1, 3'd0, 16'h0);
    get_reply(-1);
    check_reply("R5 tick survived", 1, 32'h20);
    do_cmd(2'd1, 3'd0, 16'h0);
    get_reply(-1);
    check_reply("R6 cleared all", 1, 32'h00);

    // R10 poll answer in the same cycle as a clearing ack
    arm_data = 64'h77; arm_len = LENW'(1);
    @(negedge clk);
    while (!poll_req) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_nargs = 3'd0; cmd_arg = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    get_reply(-1);
    check_reply("R10 ack beside event", 1, 32'h00);
    chk("R10 R1 event kept", irq_n, 0);
    do_cmd(2'd1, 3'd0, 16'h0);
    get_reply(-1);
    check_reply("R10 event reported", 2, 32'h7711);

    // R8 same value keeps phase, new value restarts, zero stops
    @(negedge clk);
    time_poll(n);
    repeat (30) @(negedge clk);
    do_cmd(2'd3, 3'd2, 16'h0005);
    time_poll(n);
    chk("R8 same mask keeps phase", (n >= 20 && n <= 40), 1);
    repeat (20) @(negedge clk);
    do_cmd(2'd3, 3'd2, 16'h0009);
    chk("R8 new poll_mask", poll_mask, 16'h0009);
    time_poll(n);
    chk("R8 new mask restarts period", (n >= 55 && n <= 63), 1);
    do_cmd(2'd3, 3'd2, 16'h0000);
    p0 = npoll;
    repeat (200) @(negedge clk);
    chk("R8 zero mask stops polling", npoll - p0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule